// File: doc/BRIEF.md
# PWM Output Action Qualifier with Continuous Software Force

This block turns time-base counter events into two PWM output levels, A and B. Each clock cycle in which the time base asserts its tick can carry any mix of four events: counter at zero, counter at period, counter equal to compare A while counting up, and counter equal to compare B while counting up. Each channel has its own 10-bit action word. For every event, the action word says whether the event leaves the output alone, drives it low, drives it high or toggles it. When several events arrive in one tick, a fixed priority picks a single action.

On top of the event-driven level, software can hold either output low or high with a continuous force. A force value is written into a shadow register. It moves into the active force register at a tick chosen by a reload mode: at zero, at period, at either, or at the next tick whatever the events. While a force is active, the event-driven level keeps evolving underneath it. When the force is released, the output resumes that level.

The counter, the compare logic, dead-band and trip handling all sit outside this block. The block has no data stream, so every pin is a plain control or status signal.

Top module: `pwm_aq`

## Requirements
- R1: While reset is low, and directly after it is released, both outputs are low, both active forces are disabled and the shadow force register holds zero. A tick in immediate reload mode with no write made since reset therefore leaves both outputs low.
- R2: Action words use these bit positions: the zero event is at bits 1:0, the period event at bits 3:2, compare-A-up at bits 5:4 and compare-B-up at bits 9:8. Each field is coded 00 no action, 01 drive low, 10 drive high, 11 toggle.
- R3: Outputs, event state and active forces change only at a clock edge where tick is high. Events presented without tick are ignored.
- R4: When several events occur in one tick, the action applied is taken from the highest-priority event whose field is not 00. The order, from highest to lowest, is compare-B-up, compare-A-up, period, zero.
- R5: A write strobe loads the shadow force register from the write data. Output A's force is at bits 1:0 and output B's force at bits 3:2. A write alone does not change either output.
- R6: An active force coded 01 holds its output low and one coded 10 holds it high, overriding all event actions. Codes 00 and 11 leave the output to the event logic.
- R7: The reload mode decides when the shadow moves to the active force register at a tick: 00 on a zero event, 01 on a period event, 10 on either, 11 on every tick.
- R8: While a force is active, the event-driven level keeps updating, toggles included. When the force is released, the output takes the up-to-date event-driven level.
- R9: Output A uses only the A action word and the A force. Output B uses only the B action word and the B force. The two channels are otherwise independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base tick; events count only when high |
| ev_zero | input | 1 | Counter reached zero |
| ev_period | input | 1 | Counter reached period |
| ev_cmpa_up | input | 1 | Counter equals compare A while counting up |
| ev_cmpb_up | input | 1 | Counter equals compare B while counting up |
| act_cfg_a | input | 10 | Action word for output A |
| act_cfg_b | input | 10 | Action word for output B |
| frc_wr | input | 1 | Shadow force write strobe |
| frc_wdata | input | 4 | Shadow force value (A at 1:0, B at 3:2) |
| frc_reload | input | 2 | Force reload mode |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |

## Verification
The assertions check four things on every cycle. Outputs and active forces hold while tick is low. An active low or high force is always visible on its output. A shadow write lands exactly as written. A drive-low compare-B action on A is never overridden by a lower-priority event. Other behaviour only shows up over a run of cycles, so the bench scenarios cover it: toggles accumulating under a force and reappearing on release, the exact tick at which each reload mode takes a new force, and the reset-time clearing of the shadow. These are compared with a cycle model in the bench, under directed sequences and randomised event, write and mode traffic.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;
  localparam int FLD_W = 2;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_TGL  = 2'b11
  } act_e;

  typedef enum logic [1:0] {
    RLD_ZERO = 2'b00,
    RLD_PRD  = 2'b01,
    RLD_BOTH = 2'b10,
    RLD_NOW  = 2'b11
  } rld_e;

  // next event-driven level from the present level and one action code
  function automatic logic act_apply(input logic cur, input logic [1:0] code);
    case (act_e'(code))
      ACT_LOW:  act_apply = 1'b0;
      ACT_HIGH: act_apply = 1'b1;
      ACT_TGL:  act_apply = ~cur;
      default:  act_apply = cur;
    endcase
  endfunction

  // a force code that actually holds the pin
  function automatic logic frc_on(input logic [1:0] code);
    frc_on = (code == 2'b01) || (code == 2'b10);
  endfunction
endpackage

// File: rtl/pwm_aq_evsel.sv
module pwm_aq_evsel
  import pwm_aq_pkg::*;
#(
  parameter int ACT_W   = 10,
  parameter int ZRO_LSB = 0,
  parameter int PRD_LSB = 2,
  parameter int CAU_LSB = 4,
  parameter int CBU_LSB = 8
) (
  input  logic [ACT_W-1:0] act_cfg,
  input  logic             ev_zero,
  input  logic             ev_period,
  input  logic             ev_cmpa_up,
  input  logic             ev_cmpb_up,
  output logic [FLD_W-1:0] code
);
  logic [FLD_W-1:0] f_zro, f_prd, f_cau, f_cbu;

  assign f_zro = act_cfg[ZRO_LSB +: FLD_W];
  assign f_prd = act_cfg[PRD_LSB +: FLD_W];
  assign f_cau = act_cfg[CAU_LSB +: FLD_W];
  assign f_cbu = act_cfg[CBU_LSB +: FLD_W];

  // compare-B-up highest, then compare-A-up, period, zero
  always_comb begin
    code = ACT_NONE;
    if (ev_zero    && f_zro != ACT_NONE) code = f_zro;
    if (ev_period  && f_prd != ACT_NONE) code = f_prd;
    if (ev_cmpa_up && f_cau != ACT_NONE) code = f_cau;
    if (ev_cmpb_up && f_cbu != ACT_NONE) code = f_cbu;
  end
endmodule

// File: rtl/pwm_aq_force.sv
module pwm_aq_force
  import pwm_aq_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 ev_zero,
  input  logic                 ev_period,
  input  logic [1:0]           reload,
  input  logic                 wr,
  input  logic [NCH*FLD_W-1:0] wdata,
  output logic [NCH*FLD_W-1:0] shadow_q,
  output logic [NCH*FLD_W-1:0] act_q,
  output logic [NCH*FLD_W-1:0] act_nxt
);
  logic load;

  always_comb begin
    case (rld_e'(reload))
      RLD_ZERO: load = tick && ev_zero;
      RLD_PRD:  load = tick && ev_period;
      RLD_BOTH: load = tick && (ev_zero || ev_period);
      default:  load = tick;
    endcase
  end

  assign act_nxt = load ? shadow_q : act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
      act_q    <= '0;
    end else begin
      if (wr) shadow_q <= wdata;
      act_q <= act_nxt;
    end
  end
endmodule

// File: rtl/pwm_aq_chan.sv
module pwm_aq_chan
  import pwm_aq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [FLD_W-1:0] code,
  input  logic [FLD_W-1:0] frc_nxt,
  output logic             pwm
);
  logic evt_q, evt_nxt, pwm_nxt;

  assign evt_nxt = tick ? act_apply(evt_q, code) : evt_q;
  assign pwm_nxt = !tick ? pwm :
                   frc_on(frc_nxt) ? frc_nxt[1] : evt_nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_q <= 1'b0;
      pwm   <= 1'b0;
    end else begin
      evt_q <= evt_nxt;
      pwm   <= pwm_nxt;
    end
  end
endmodule

// File: rtl/pwm_aq.sv
module pwm_aq
  import pwm_aq_pkg::*;
#(
  parameter int ACT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ev_zero,
  input  logic             ev_period,
  input  logic             ev_cmpa_up,
  input  logic             ev_cmpb_up,
  input  logic [ACT_W-1:0] act_cfg_a,
  input  logic [ACT_W-1:0] act_cfg_b,
  input  logic             frc_wr,
  input  logic [3:0]       frc_wdata,
  input  logic [1:0]       frc_reload,
  output logic             pwm_a,
  output logic             pwm_b
);
  localparam int NCH = 2;
  localparam int FW  = NCH * FLD_W;

  logic [ACT_W-1:0] cfg   [NCH];
  logic [FLD_W-1:0] code  [NCH];
  logic [NCH-1:0]   pwm_v;
  logic [FW-1:0]    frc_act, frc_nxt, frc_shadow;

  assign cfg[0] = act_cfg_a;
  assign cfg[1] = act_cfg_b;

  pwm_aq_force #(.NCH(NCH)) u_frc (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .ev_zero(ev_zero), .ev_period(ev_period),
    .reload(frc_reload), .wr(frc_wr), .wdata(frc_wdata),
    .shadow_q(frc_shadow), .act_q(frc_act), .act_nxt(frc_nxt)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwm_aq_evsel #(.ACT_W(ACT_W)) u_sel (
      .act_cfg(cfg[c]), .ev_zero(ev_zero), .ev_period(ev_period),
      .ev_cmpa_up(ev_cmpa_up), .ev_cmpb_up(ev_cmpb_up), .code(code[c])
    );
    pwm_aq_chan u_ch (
      .clk(clk), .rst_n(rst_n), .tick(tick), .code(code[c]),
      .frc_nxt(frc_nxt[c*FLD_W +: FLD_W]), .pwm(pwm_v[c])
    );
  end

  assign pwm_a = pwm_v[0];
  assign pwm_b = pwm_v[1];
endmodule

// File: rtl/pwm_aq_chk.sv
module pwm_aq_chk #(
  parameter int ACT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             ev_cmpb_up,
  input logic [ACT_W-1:0] act_cfg_a,
  input logic             frc_wr,
  input logic [3:0]       frc_wdata,
  input logic             pwm_a,
  input logic             pwm_b,
  input logic [3:0]       frc_act,
  input logic [3:0]       frc_shadow
);
  // R3
  hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pwm_a));
  // R3
  hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pwm_b));
  // R3
  frc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(frc_act));
  // R6
  frc_lo_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frc_act[1:0] == 2'b01) |-> !pwm_a);
  // R6
  frc_hi_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frc_act[3:2] == 2'b10) |-> pwm_b);
  // R5
  shadow_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frc_wr |=> (frc_shadow == $past(frc_wdata)));
  // R4
  cbu_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ev_cmpb_up && act_cfg_a[9:8] == 2'b01) |=>
      ((frc_act[1:0] == 2'b10) || !pwm_a));
endmodule

bind pwm_aq pwm_aq_chk #(.ACT_W(ACT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .ev_cmpb_up(ev_cmpb_up),
  .act_cfg_a(act_cfg_a), .frc_wr(frc_wr), .frc_wdata(frc_wdata),
  .pwm_a(pwm_a), .pwm_b(pwm_b), .frc_act(frc_act), .frc_shadow(frc_shadow)
);

// File: tb/tb_pwm_aq.sv
module tb_pwm_aq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, ev_zero = 0, ev_period = 0, ev_cmpa_up = 0, ev_cmpb_up = 0;
  logic [9:0] act_cfg_a = '0, act_cfg_b = '0;
  logic frc_wr = 0;
  logic [3:0] frc_wdata = '0;
  logic [1:0] frc_reload = '0;
  logic pwm_a, pwm_b;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // bench model state
  logic       m_ev [2];
  logic       m_out[2];
  logic [1:0] m_fa [2];
  logic [3:0] m_sh;

  always #10 clk = ~clk;

  pwm_aq dut (.*);

  function automatic logic [1:0] pick(input logic [9:0] w, input logic z, p, a, b);
    logic [1:0] r = 2'b00;
    if (b && w[9:8] != 0)      r = w[9:8];
    else if (a && w[5:4] != 0) r = w[5:4];
    else if (p && w[3:2] != 0) r = w[3:2];
    else if (z && w[1:0] != 0) r = w[1:0];
    return r;
  endfunction

  function automatic logic step_lvl(input logic cur, input logic [1:0] c);
    return (c == 2'b01) ? 1'b0 : (c == 2'b10) ? 1'b1 : (c == 2'b11) ? !cur : cur;
  endfunction

  task automatic check(input string tag, input logic got, input logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_ev[c] = 0; m_out[c] = 0; m_fa[c] = 0;
    end
    m_sh = '0;
  endtask

  // apply one cycle of inputs, advance the model, compare after the edge
  task automatic cyc(input logic t, z, p, a, b, w, input logic [3:0] wd,
                     input logic [1:0] rl, input string tag);
    logic ld;
    tick = t; ev_zero = z; ev_period = p; ev_cmpa_up = a; ev_cmpb_up = b;
    frc_wr = w; frc_wdata = wd; frc_reload = rl;
    ld = t && ((rl == 0 && z) || (rl == 1 && p) || (rl == 2 && (z || p)) || rl == 3);
    for (int c = 0; c < 2; c++) begin
      logic [1:0] fc;
      if (t) m_ev[c] = step_lvl(m_ev[c], pick(c == 0 ? act_cfg_a : act_cfg_b, z, p, a, b));
      if (ld) m_fa[c] = m_sh[2*c +: 2];
      fc = m_fa[c];
      if (t) m_out[c] = (fc == 2'b01) ? 1'b0 : (fc == 2'b10) ? 1'b1 : m_ev[c];
    end
    if (w) m_sh = wd;
    @(posedge clk);
    #5;
    check({tag, " A"}, pwm_a, m_out[0]);
    check({tag, " B"}, pwm_b, m_out[1]);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(posedge clk);
    #5;
    check("R1 reset A", pwm_a, 1'b0);
    check("R1 reset B", pwm_b, 1'b0);
    rst_n = 1;
    @(posedge clk); #5;
    check("R1 release A", pwm_a, 1'b0);
    cyc(1, 0, 0, 0, 0, 0, 4'h0, 2'd3, "R1 shadow clear");

    // R2 field positions and codes
    act_cfg_a = 10'h002; act_cfg_b = 10'h003;
    cyc(1, 1, 0, 0, 0, 0, 0, 0, "R2 zero");
    act_cfg_a = 10'h010; act_cfg_b = 10'h200;
    cyc(1, 0, 0, 1, 0, 0, 0, 0, "R2 cau");
    cyc(1, 0, 0, 0, 1, 0, 0, 0, "R2 cbu");
    act_cfg_a = 10'h00C;
    cyc(1, 0, 1, 0, 0, 0, 0, 0, "R2 prd toggle");
    cyc(1, 0, 1, 0, 0, 0, 0, 0, "R2 prd toggle");

    // R3 events without tick
    cyc(0, 1, 1, 1, 1, 0, 0, 0, "R3 no tick");

    // R4 priority, R9 independence with inverted B
    act_cfg_a = 10'h31A; act_cfg_b = 10'h205;
    cyc(1, 1, 1, 1, 1, 0, 0, 0, "R4 all events");
    act_cfg_a = 10'h01A;
    cyc(1, 1, 1, 1, 1, 0, 0, 0, "R4 cau wins");
    cyc(1, 1, 1, 0, 0, 0, 0, 0, "R9 zero+prd");

    // R5 write alone, R7 reload at zero
    act_cfg_a = 10'h003; act_cfg_b = 10'h003;
    cyc(1, 0, 0, 0, 0, 1, 4'b1001, 2'd0, "R5 write");
    cyc(1, 0, 1, 0, 0, 0, 0, 2'd0, "R7 mode0 prd");
    cyc(1, 1, 0, 0, 0, 0, 0, 2'd0, "R6 forced");
    // R8 toggles underneath
    cyc(1, 1, 0, 0, 0, 1, 4'b0000, 2'd1, "R8 toggle under force");
    cyc(1, 1, 0, 0, 0, 0, 0, 2'd1, "R7 mode1 zero");
    cyc(1, 0, 1, 0, 0, 0, 0, 2'd1, "R8 release");
    cyc(1, 0, 0, 0, 0, 1, 4'b0110, 2'd2, "R5 write2");
    cyc(1, 0, 1, 0, 0, 0, 0, 2'd2, "R7 mode2 prd");
    cyc(1, 0, 0, 0, 0, 1, 4'b1111, 2'd3, "R6 code11");
    cyc(1, 0, 0, 0, 0, 0, 0, 2'd3, "R7 mode3 next tick");

    // randomised traffic
    for (int i = 0; i < 3000; i++) begin
      if (i % 50 == 0) begin
        act_cfg_a = 10'($urandom); act_cfg_b = 10'($urandom);
      end
      cyc($urandom_range(0, 9) < 7, 1'($urandom), 1'($urandom), 1'($urandom),
          1'($urandom), $urandom_range(0, 9) == 0, 4'($urandom),
          2'($urandom), "R2 R4 R6 R7 R8 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule